// File: doc/BRIEF.md
# Splittable Timer with Per-Half Compare and Overflow Flags

The block is an up-counter that software configures either as one 16-bit counter or as two independent 8-bit counters: a high byte and a low byte. It advances by one on every clock cycle in which the count-enable tick input is high. Each byte has its own compare register. Clear-on-compare can be enabled separately for each half. Each half also has an overflow flag, and an interrupt request is raised when that flag is set and its enable bit is on.

A single control/status register holds several fields: the mode bit, the two clear-on-compare bits, the two interrupt enables and the two overflow flags. A flag cannot be set by software. It is cleared only by writing 0 to it after a read of that register has returned it as 1. Software reaches every register through a simple synchronous bus, which has an address, write data, a write strobe, a read strobe and registered read data.

Top module: `split_timer`

## Requirements
- R1: After reset, every control/status bit is 0, both counter bytes are 0x00, both compare bytes are 0xFF, and both interrupt outputs are low.
- R2: With the mode bit (control bit 0) at 0, each tick increments the low byte and the high byte independently. A low byte wrapping from 0xFF to 0x00 does not change the high byte.
- R3: With the mode bit at 1, the concatenation {high, low} counts as one 16-bit value. The carry out of the low byte increments the high byte, and 0xFFFF wraps to 0x0000.
- R4: Without a tick, the counters hold their value. A bus write to either counter byte loads the written value and suppresses counting for that cycle in both bytes.
- R5: In 8-bit mode, control bit 2 (high clear) makes the high byte go to 0x00 on a tick where it equals the high compare byte. Control bit 1 (low clear) does the same for the low byte against the low compare byte.
- R6: In 16-bit mode, control bit 2 makes the full counter go to 0x0000 on a tick where it equals {compare high, compare low}. Control bit 1 has no effect in 16-bit mode.
- R7: Control bit 5 (low flag) sets when the low byte is incremented from 0xFF to 0x00, in either mode. Control bit 6 (high flag) sets when the high byte wraps in 8-bit mode, or when the full counter wraps from 0xFFFF in 16-bit mode. A return to 0 caused by compare clearing sets no flag.
- R8: Writing 0 to a flag bit clears it only if a read of the control register has returned that flag as 1 since the last accepted clear. Writing 0 without such a read leaves the flag set, and writing 1 never sets it.
- R9: If hardware sets a flag in the same cycle that an armed clearing write arrives, the flag stays set. The arming is consumed, so a further write of 0 needs a new read first.
- R10: The low interrupt output equals low flag AND control bit 3. The high interrupt output equals high flag AND control bit 4. Each stays high until its flag is cleared.
- R11: Read data is registered and valid the cycle after the read strobe. The address map is 0 = control/status, 1 = counter high, 2 = counter low, 3 = compare high and 4 = compare low. Any other address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register address |
| busWrData | input | DATA_W | Write data |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | DATA_W | Registered read data |
| countTick | input | 1 | Count enable, one step per high cycle |
| irqLow | output | 1 | Low-byte overflow interrupt request |
| irqHigh | output | 1 | High-byte or 16-bit overflow interrupt request |

## Verification
The timing of each result is fixed:
- A tick, a counter write or a control write changes the counters, flags and interrupt outputs at the next rising edge.
- Read data appears one edge after the read strobe.
- A flag raised by a tick therefore shows on its interrupt output in the cycle right after that tick.

The bench drives all inputs on the falling edge and samples one falling edge later, so every value it checks is due by then. A random phase tracks a cycle-level model of counters and flags that is advanced only on cycles whose tick was high. Directed cases put the hardware set and the software clear of a flag into the same edge.

// File: rtl/split_timer_pkg.sv
`timescale 1ns/1ps
package split_timer_pkg;

  // register addresses
  localparam int ADDR_CSR  = 0;
  localparam int ADDR_CNTH = 1;
  localparam int ADDR_CNTL = 2;
  localparam int ADDR_CMPH = 3;
  localparam int ADDR_CMPL = 4;

  // control/status bit positions; half index 0 = low, 1 = high
  localparam int BIT_MODE = 0;
  localparam int BIT_CLR  = 1;
  localparam int BIT_IE   = 3;
  localparam int BIT_OVF  = 5;
  localparam int NUM_HALF = 2;

  typedef struct packed {
    logic [NUM_HALF-1:0] wrCnt;
    logic [NUM_HALF-1:0] wrCmp;
    logic                mode16;
    logic [NUM_HALF-1:0] clrEn;
  } dpCmd_t;

endpackage

// File: rtl/split_timer_dp.sv
`timescale 1ns/1ps
module split_timer_dp
  import split_timer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  dpCmd_t              cmd,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   cntHi,
  output logic [DATA_W-1:0]   cntLo,
  output logic [DATA_W-1:0]   cmpHi,
  output logic [DATA_W-1:0]   cmpLo,
  output logic [NUM_HALF-1:0] ovfEvt
);

  localparam int FULL_W = NUM_HALF * DATA_W;

  logic [DATA_W-1:0] cnt [NUM_HALF];
  logic [DATA_W-1:0] cmp [NUM_HALF];

  logic [DATA_W-1:0]   halfNext [NUM_HALF];
  logic [NUM_HALF-1:0] halfMatch, halfClr, halfWrap, wrap16;

  logic [FULL_W-1:0] full, cmpFull, full16Next;
  logic              match16, clr16, stall, advance;

  assign stall   = |cmd.wrCnt;
  assign advance = tick && !stall;

  // independent 8-bit next-state per half
  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    assign halfMatch[h] = (cnt[h] == cmp[h]);
    assign halfClr[h]   = cmd.clrEn[h] && halfMatch[h];
    assign halfNext[h]  = halfClr[h] ? '0 : cnt[h] + 1'b1;
    assign halfWrap[h]  = !halfClr[h] && (cnt[h] == {DATA_W{1'b1}});
  end

  // joined 16-bit next-state
  assign full       = {cnt[1], cnt[0]};
  assign cmpFull    = {cmp[1], cmp[0]};
  assign match16    = (full == cmpFull);
  assign clr16      = cmd.clrEn[1] && match16;
  assign full16Next = clr16 ? '0 : full + 1'b1;
  assign wrap16[0]  = !clr16 && (cnt[0] == {DATA_W{1'b1}});
  assign wrap16[1]  = !clr16 && (full == {FULL_W{1'b1}});

  assign ovfEvt = advance ? (cmd.mode16 ? wrap16 : halfWrap) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int h = 0; h < NUM_HALF; h++) begin
        cnt[h] <= '0;
        cmp[h] <= '1;
      end
    end else begin
      for (int h = 0; h < NUM_HALF; h++) begin
        if (cmd.wrCmp[h]) cmp[h] <= wrData;
        if (cmd.wrCnt[h])
          cnt[h] <= wrData;
        else if (advance)
          cnt[h] <= cmd.mode16 ? full16Next[h*DATA_W +: DATA_W] : halfNext[h];
      end
    end
  end

  assign cntHi = cnt[1];
  assign cntLo = cnt[0];
  assign cmpHi = cmp[1];
  assign cmpLo = cmp[0];

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !stall) |=> ($stable(cntHi) && $stable(cntLo)));

  // R3
  wrap16_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.mode16 && advance && (full == {FULL_W{1'b1}}) && !(cmd.clrEn[1] && match16))
      |=> ({cntHi, cntLo} == '0));

  // R5
  clr8_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.mode16 && advance && cmd.clrEn[0] && (cntLo == cmpLo)) |=> (cntLo == '0));

  // R6
  clr16_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.mode16 && advance && cmd.clrEn[1] && ({cntHi, cntLo} == {cmpHi, cmpLo}))
      |=> ({cntHi, cntLo} == '0));

endmodule

// File: rtl/split_timer_ctrl.sv
`timescale 1ns/1ps
module split_timer_ctrl
  import split_timer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [DATA_W-1:0]   cntHi,
  input  logic [DATA_W-1:0]   cntLo,
  input  logic [DATA_W-1:0]   cmpHi,
  input  logic [DATA_W-1:0]   cmpLo,
  input  logic [NUM_HALF-1:0] ovfEvt,
  output dpCmd_t              cmd,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_HALF-1:0] irq
);

  logic                mode16Q;
  logic [NUM_HALF-1:0] clrQ, ieQ, ovfQ, armQ, clearHit;
  logic                wrCsr, rdCsr;
  logic [DATA_W-1:0]   csrVal, rdNext;

  assign wrCsr = wrEn && (addr == ADDR_W'(ADDR_CSR));
  assign rdCsr = rdEn && (addr == ADDR_W'(ADDR_CSR));

  assign cmd.wrCnt[1] = wrEn && (addr == ADDR_W'(ADDR_CNTH));
  assign cmd.wrCnt[0] = wrEn && (addr == ADDR_W'(ADDR_CNTL));
  assign cmd.wrCmp[1] = wrEn && (addr == ADDR_W'(ADDR_CMPH));
  assign cmd.wrCmp[0] = wrEn && (addr == ADDR_W'(ADDR_CMPL));
  assign cmd.mode16   = mode16Q;
  assign cmd.clrEn    = clrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode16Q <= 1'b0;
      clrQ    <= '0;
      ieQ     <= '0;
    end else if (wrCsr) begin
      mode16Q <= wrData[BIT_MODE];
      clrQ    <= wrData[BIT_CLR +: NUM_HALF];
      ieQ     <= wrData[BIT_IE +: NUM_HALF];
    end
  end

  // per-flag read-then-write-zero handshake
  for (genvar h = 0; h < NUM_HALF; h++) begin : g_flag
    assign clearHit[h] = wrCsr && !wrData[BIT_OVF + h] && armQ[h];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ovfQ[h] <= 1'b0;
        armQ[h] <= 1'b0;
      end else begin
        if (ovfEvt[h])        ovfQ[h] <= 1'b1;
        else if (clearHit[h]) ovfQ[h] <= 1'b0;
        if (clearHit[h])              armQ[h] <= 1'b0;
        else if (rdCsr && ovfQ[h])    armQ[h] <= 1'b1;
      end
    end

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ovfQ[h] && !armQ[h]) |=> ovfQ[h]);

    // R7
    flag_src_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!ovfQ[h] && !ovfEvt[h]) |=> !ovfQ[h]);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ovfEvt[h] && clearHit[h]) |=> (ovfQ[h] && !armQ[h]));
  end

  always_comb begin
    csrVal = '0;
    csrVal[BIT_MODE]            = mode16Q;
    csrVal[BIT_CLR +: NUM_HALF] = clrQ;
    csrVal[BIT_IE +: NUM_HALF]  = ieQ;
    csrVal[BIT_OVF +: NUM_HALF] = ovfQ;
  end

  always_comb begin
    case (int'(addr))
      ADDR_CSR:  rdNext = csrVal;
      ADDR_CNTH: rdNext = cntHi;
      ADDR_CNTL: rdNext = cntLo;
      ADDR_CMPH: rdNext = cmpHi;
      ADDR_CMPL: rdNext = cmpLo;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdNext;
  end

  assign irq = ovfQ & ieQ;

endmodule

// File: rtl/split_timer.sv
`timescale 1ns/1ps
module split_timer
  import split_timer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic              countTick,
  output logic              irqLow,
  output logic              irqHigh
);

  dpCmd_t              cmd;
  logic [DATA_W-1:0]   cntHi, cntLo, cmpHi, cmpLo;
  logic [NUM_HALF-1:0] ovfEvt, irq;

  split_timer_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (busAddr),
    .wrData (busWrData),
    .wrEn   (busWrEn),
    .rdEn   (busRdEn),
    .cntHi  (cntHi),
    .cntLo  (cntLo),
    .cmpHi  (cmpHi),
    .cmpLo  (cmpLo),
    .ovfEvt (ovfEvt),
    .cmd    (cmd),
    .rdData (busRdData),
    .irq    (irq)
  );

  split_timer_dp #(.DATA_W(DATA_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (countTick),
    .cmd    (cmd),
    .wrData (busWrData),
    .cntHi  (cntHi),
    .cntLo  (cntLo),
    .cmpHi  (cmpHi),
    .cmpLo  (cmpLo),
    .ovfEvt (ovfEvt)
  );

  assign irqLow  = irq[0];
  assign irqHigh = irq[1];

endmodule

// File: tb/split_timer_tb.sv
`timescale 1ns/1ps
module split_timer_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busRdData;
  logic       countTick = 1'b0;
  logic       irqLow, irqHigh;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model state for the random phase
  logic [7:0] mHi, mLo, mCmpHi, mCmpLo;
  logic       mMode, mClrLo, mClrHi, mOvfLo, mOvfHi;

  always #2.5 clk = ~clk;

  split_timer dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busRdData(busRdData),
    .countTick(countTick), .irqLow(irqLow), .irqHigh(irqHigh)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    countTick = 1'b0; busWrEn = 1'b0; busRdEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk);
      countTick = 1'b1;
    end
    @(negedge clk);
    countTick = 1'b0;
  endtask

  function automatic logic [7:0] csrExp(input logic mode, input logic clrLo,
      input logic clrHi, input logic ieLo, input logic ieHi,
      input logic ovfLo, input logic ovfHi);
    return {1'b0, ovfHi, ovfLo, ieHi, ieLo, clrHi, clrLo, mode};
  endfunction

  // one counting step of the reference model
  task automatic modelStep();
    logic [15:0] f;
    if (mMode) begin
      f = {mHi, mLo};
      if (mClrHi && f == {mCmpHi, mCmpLo}) f = 16'h0;
      else begin
        if (mLo == 8'hFF) mOvfLo = 1'b1;
        if (f == 16'hFFFF) mOvfHi = 1'b1;
        f = f + 16'h1;
      end
      {mHi, mLo} = f;
    end else begin
      if (mClrLo && mLo == mCmpLo) mLo = 8'h0;
      else begin
        if (mLo == 8'hFF) mOvfLo = 1'b1;
        mLo = mLo + 8'h1;
      end
      if (mClrHi && mHi == mCmpHi) mHi = 8'h0;
      else begin
        if (mHi == 8'hFF) mOvfHi = 1'b1;
        mHi = mHi + 8'h1;
      end
    end
  endtask

  initial begin
    logic [7:0] rd;
    void'($urandom(32'd4711));
    doReset();

    // R1 reset state
    busRead(3'd0, rd); check("R1", "csr", rd, 8'h00);
    busRead(3'd1, rd); check("R1", "cntHi", rd, 8'h00);
    busRead(3'd2, rd); check("R1", "cntLo", rd, 8'h00);
    busRead(3'd3, rd); check("R1", "cmpHi", rd, 8'hFF);
    busRead(3'd4, rd); check("R1", "cmpLo", rd, 8'hFF);
    check("R1", "irqs", {irqHigh, irqLow}, 2'b00);
    // R11 unmapped address
    busRead(3'd6, rd); check("R11", "unmapped", rd, 8'h00);

    // R4 no tick holds; write with tick suppresses counting
    repeat (5) @(negedge clk);
    busRead(3'd2, rd); check("R4", "cntLo idle", rd, 8'h00);
    @(negedge clk);
    countTick = 1'b1; busAddr = 3'd1; busWrData = 8'h40; busWrEn = 1'b1;
    @(negedge clk);
    countTick = 1'b0; busWrEn = 1'b0;
    busRead(3'd1, rd); check("R4", "cntHi written", rd, 8'h40);
    busRead(3'd2, rd); check("R4", "cntLo stalled", rd, 8'h00);

    // R2 8-bit independence, R7 low flag, R10 gating with enable off
    doReset();
    busWrite(3'd1, 8'h10);
    busWrite(3'd2, 8'hFE);
    ticks(3);
    busRead(3'd2, rd); check("R2", "cntLo", rd, 8'h01);
    busRead(3'd1, rd); check("R2", "cntHi", rd, 8'h13);
    check("R10", "irqLow gated off", irqLow, 1'b0);
    busRead(3'd0, rd); check("R7", "csr low flag", rd, 8'h20);

    // R8 handshake and R10 interrupt
    doReset();
    busWrite(3'd0, 8'h08);
    busWrite(3'd2, 8'hFF);
    ticks(1);
    check("R10", "irqLow raised", irqLow, 1'b1);
    busWrite(3'd0, 8'h08);
    check("R8", "clear without read", irqLow, 1'b1);
    busWrite(3'd0, 8'h28);
    check("R8", "write one keeps", irqLow, 1'b1);
    busRead(3'd0, rd); check("R8", "csr read", rd, 8'h28);
    busWrite(3'd0, 8'h08);
    check("R8", "armed clear", irqLow, 1'b0);
    busWrite(3'd0, 8'h28);
    check("R8", "write one no set", irqLow, 1'b0);

    // R9 set wins against a simultaneous armed clear
    busWrite(3'd2, 8'hFF);
    ticks(1);
    busRead(3'd0, rd); check("R9", "flag set", rd, 8'h28);
    busWrite(3'd2, 8'hFF);
    @(negedge clk);
    countTick = 1'b1; busAddr = 3'd0; busWrData = 8'h08; busWrEn = 1'b1;
    @(negedge clk);
    countTick = 1'b0; busWrEn = 1'b0;
    check("R9", "set wins", irqLow, 1'b1);
    busWrite(3'd0, 8'h08);
    check("R9", "arm consumed", irqLow, 1'b1);
    busRead(3'd0, rd);
    busWrite(3'd0, 8'h08);
    check("R9", "rearmed clear", irqLow, 1'b0);

    // R3 16-bit carry and full wrap
    doReset();
    busWrite(3'd0, 8'h19);
    busWrite(3'd1, 8'h12);
    busWrite(3'd2, 8'hFF);
    ticks(1);
    busRead(3'd1, rd); check("R3", "carry cntHi", rd, 8'h13);
    busRead(3'd2, rd); check("R3", "carry cntLo", rd, 8'h00);
    check("R7", "low flag in 16-bit", irqLow, 1'b1);
    check("R7", "no high flag", irqHigh, 1'b0);
    busWrite(3'd1, 8'hFF);
    busWrite(3'd2, 8'hFF);
    ticks(1);
    busRead(3'd1, rd); check("R3", "wrap cntHi", rd, 8'h00);
    busRead(3'd2, rd); check("R3", "wrap cntLo", rd, 8'h00);
    check("R7", "high flag 16-bit wrap", irqHigh, 1'b1);

    // R6 16-bit compare clear, low clear bit ignored
    doReset();
    busWrite(3'd0, 8'h07);
    busWrite(3'd3, 8'h02);
    busWrite(3'd4, 8'h04);
    busWrite(3'd1, 8'h01);
    busWrite(3'd2, 8'h04);
    ticks(1);
    busRead(3'd2, rd); check("R6", "low clear ignored", rd, 8'h05);
    busWrite(3'd3, 8'h01);
    busWrite(3'd4, 8'h05);
    ticks(1);
    busRead(3'd1, rd); check("R6", "cleared cntHi", rd, 8'h00);
    busRead(3'd2, rd); check("R6", "cleared cntLo", rd, 8'h00);
    busRead(3'd0, rd); check("R7", "no flag on clear 16", rd, 8'h07);

    // R5 8-bit per-half compare clear
    doReset();
    busWrite(3'd0, 8'h06);
    busWrite(3'd3, 8'h03);
    busWrite(3'd4, 8'h10);
    busWrite(3'd1, 8'h02);
    busWrite(3'd2, 8'h0F);
    ticks(1);
    busRead(3'd1, rd); check("R5", "cntHi at match", rd, 8'h03);
    busRead(3'd2, rd); check("R5", "cntLo at match", rd, 8'h10);
    ticks(1);
    busRead(3'd1, rd); check("R5", "cntHi cleared", rd, 8'h00);
    busRead(3'd2, rd); check("R5", "cntLo cleared", rd, 8'h00);
    busRead(3'd0, rd); check("R7", "no flag on clear 8", rd, 8'h06);

    // random phase against the bench model
    doReset();
    mOvfLo = 1'b0; mOvfHi = 1'b0;
    for (int it = 0; it < 40; it++) begin
      int n;
      string tg;
      mMode  = 1'($urandom % 2);
      mClrLo = 1'($urandom % 2);
      mClrHi = 1'($urandom % 2);
      mCmpHi = 8'($urandom % 2 ? 8'hF0 + $urandom % 16 : $urandom % 256);
      mCmpLo = 8'($urandom % 2 ? 8'hF0 + $urandom % 16 : $urandom % 256);
      mHi    = 8'($urandom % 2 ? 8'hF0 + $urandom % 16 : $urandom % 256);
      mLo    = 8'($urandom % 2 ? 8'hF0 + $urandom % 16 : $urandom % 256);
      busWrite(3'd0, csrExp(mMode, mClrLo, mClrHi, 1'b0, 1'b0, 1'b0, 1'b0));
      busWrite(3'd3, mCmpHi);
      busWrite(3'd4, mCmpLo);
      busWrite(3'd1, mHi);
      busWrite(3'd2, mLo);
      n = 1 + int'($urandom % 40);
      for (int c = 0; c < n; c++) begin
        logic t;
        t = ($urandom % 4) != 0;
        @(negedge clk);
        countTick = t;
        if (t) modelStep();
      end
      @(negedge clk);
      countTick = 1'b0;
      tg = mMode ? "R3/R6" : "R2/R5";
      busRead(3'd1, rd); check(tg, "random cntHi", rd, mHi);
      busRead(3'd2, rd); check(tg, "random cntLo", rd, mLo);
      busRead(3'd0, rd);
      check("R7", "random csr", rd,
            csrExp(mMode, mClrLo, mClrHi, 1'b0, 1'b0, mOvfLo, mOvfHi));
      busWrite(3'd0, csrExp(mMode, mClrLo, mClrHi, 1'b0, 1'b0, 1'b0, 1'b0));
      mOvfLo = 1'b0; mOvfHi = 1'b0;
      busRead(3'd0, rd);
      check("R8", "random flags cleared", rd,
            csrExp(mMode, mClrLo, mClrHi, 1'b0, 1'b0, 1'b0, 1'b0));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule